// File: doc/BRIEF.md
# Converter Output FIFO Controller

This block sits between the result side of a sample-rate conversion datapath and a CPU that drains an eight-entry output FIFO. Each result-valid strobe from the datapath becomes a FIFO entry. The CPU reads the entries in arrival order through a show-ahead read port. The block watches for two error conditions:

- a CPU read while the FIFO is empty (underflow);
- a result completing while the FIFO is full (overwrite).

Each condition has its own sticky status flag and its own interrupt enable.

An overwrite is never lost. The offending result is parked in a one-entry holding register, and the datapath is held off while that register is occupied. What happens next depends on the overwrite interrupt enable:

- **Enable set (stall policy):** the parked result stays put until the CPU clears the overwrite flag.
- **Enable clear (auto policy):** the flag clears itself as soon as a slot frees, and the parked result moves into the FIFO on that same edge.

A control register also carries a write-one flush command. The command is checked against the converter enable and against the input-buffer fill level. The outcome is either a flush start pulse or a work-memory clear pulse.

Top module: `cvt_ofifo_ctrl`

## Requirements
- R1: After reset, the FIFO level is 0, both status flags are 0, the control readback is 0, and irq, conv_hold, flush_go and work_clr are all 0.
- R2: Results accepted on res_valid are returned on rd_data in arrival order. rd_data always shows the oldest entry. fifo_level counts the entries, up to 8.
- R3: A read with rd_en while fifo_level is 0 sets status bit 0 (underflow) on the next cycle and leaves the level at 0.
- R4: A result arriving while fifo_level is 8, with no read in the same cycle, sets status bit 1 (overwrite) and raises conv_hold on the next cycle. The level stays at 8.
- R5: irq is high exactly when (status bit 0 and control bit 1) or (status bit 1 and control bit 2) is true. Control bit 1 is the underflow enable and control bit 2 is the overwrite enable.
- R6: With control bit 2 set, the parked result is not written while the overwrite flag is set, even after slots free. It is written on the cycle after the flag clears.
- R7: With control bit 2 clear, a read from a full FIFO clears the overwrite flag, writes the parked result, and drops conv_hold, all on the same edge.
- R8: Writing 1 to a bit of sts_wdata with sts_we clears that status flag. A set event in the same cycle wins, and the flag stays 1.
- R9: Control bit 3 (flush) always reads back 0. A flush write while the stored converter enable (control bit 0) is 0 produces neither flush_go nor work_clr.
- R10: A flush write with the converter enabled gives a one-cycle flush_go when in_count is at least MIN_IN, and a one-cycle work_clr otherwise. Both pulses come one cycle after the write.
- R11: No accepted result is dropped under either overwrite policy. The parked result comes out last, after the entries that were already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result complete strobe |
| res_data | input | DATA_W | Conversion result |
| conv_hold | output | 1 | Holds off the datapath while a result is parked |
| rd_en | input | 1 | CPU read of the output FIFO |
| rd_data | output | DATA_W | Oldest FIFO entry (show-ahead) |
| fifo_level | output | $clog2(DEPTH+1) | Number of stored entries |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Bit 0 enable, bit 1 underflow irq enable, bit 2 overwrite irq enable, bit 3 flush |
| ctl_rdata | output | 4 | Control readback; bit 3 is always 0 |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 2 | Write 1 to clear: bit 0 underflow, bit 1 overwrite |
| sts_rdata | output | 2 | Bit 0 underflow flag, bit 1 overwrite flag |
| in_count | input | CNT_W | Input-buffer sample count |
| flush_go | output | 1 | One-cycle flush start |
| work_clr | output | 1 | One-cycle work-memory clear |
| irq | output | 1 | Level interrupt request |

## Verification
The bench fills the FIFO to exactly eight entries and then pushes one more result under each overwrite policy.

- **Stall policy:** it frees slots before clearing the flag. A design that leaked the parked result early would show a rising level, and one that dropped it would lose the last scoreboard item.
- **Auto policy:** it reads from a full FIFO. A design that cleared the flag one cycle late, or kept conv_hold up, fails at the very next sample.
- **Clear versus set:** it clears the underflow flag in the same cycle as a fresh empty read. A design that gives the clear priority shows the flag at 0.
- **Flush:** it issues flush writes with the converter disabled, with in_count exactly at MIN_IN, and one below MIN_IN. This catches an off-by-one threshold or an enable check that is missing.

// File: rtl/cvt_ofifo_pkg.sv
package cvt_ofifo_pkg;
  // control register bit positions
  localparam int CTL_W   = 4;
  localparam int CTL_EN  = 0;
  localparam int CTL_UIE = 1;
  localparam int CTL_OIE = 2;
  localparam int CTL_FL  = 3;
  // status register bit positions
  localparam int STS_W   = 2;
  localparam int STS_UNF = 0;
  localparam int STS_OVF = 1;

  typedef struct packed {
    logic oie;
    logic uie;
    logic en;
  } ctl_t;
endpackage

// File: rtl/cvt_ofifo_store.sv
module cvt_ofifo_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LW-1:0]     level
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wp_d  = wr_en ? bump(wp_q) : wp_q;
    rp_d  = rd_en ? bump(rp_q) : rp_q;
    lvl_d = lvl_q;
    if (wr_en && !rd_en)      lvl_d = lvl_q + LW'(1);
    else if (!wr_en && rd_en) lvl_d = lvl_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  // data storage carries no reset
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wp_q == AW'(i))) mem_q[i] <= wr_data;
    end
  end

  assign rd_data = mem_q[rp_q];
  assign level   = lvl_q;
endmodule

// File: rtl/cvt_ofifo_flags.sv
module cvt_ofifo_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic unf_set,
  input  logic unf_clr,
  input  logic ovf_set,
  input  logic ovf_clr,
  output logic unf_q,
  output logic ovf_q
);
  logic unf_d, ovf_d;

  // a set event outranks any clear
  always_comb begin
    unf_d = unf_q;
    if (unf_set)      unf_d = 1'b1;
    else if (unf_clr) unf_d = 1'b0;
    ovf_d = ovf_q;
    if (ovf_set)      ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      unf_q <= unf_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/cvt_ofifo_flush.sv
module cvt_ofifo_flush #(
  parameter int CNT_W  = 6,
  parameter int MIN_IN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fl_req,
  input  logic             conv_en,
  input  logic [CNT_W-1:0] in_count,
  output logic             go,
  output logic             clr
);
  localparam logic [CNT_W:0] MIN_EXT = (CNT_W + 1)'(MIN_IN);

  logic enough, go_d, clr_d, go_q, clr_q;

  always_comb begin
    enough = ({1'b0, in_count} >= MIN_EXT);
    go_d   = fl_req && conv_en && enough;
    clr_d  = fl_req && conv_en && !enough;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      go_q  <= go_d;
      clr_q <= clr_d;
    end
  end

  assign go  = go_q;
  assign clr = clr_q;
endmodule

// File: rtl/cvt_ofifo_ctrl.sv
module cvt_ofifo_ctrl
  import cvt_ofifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 6,
  parameter int MIN_IN = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              conv_hold,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  fifo_level,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              sts_we,
  input  logic [STS_W-1:0]  sts_wdata,
  output logic [STS_W-1:0]  sts_rdata,
  input  logic [CNT_W-1:0]  in_count,
  output logic              flush_go,
  output logic              work_clr,
  output logic              irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic rs1_q, rs2_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sn = rs2_q;

  // control register
  ctl_t ctl_q, ctl_d;
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d.en  = ctl_wdata[CTL_EN];
      ctl_d.uie = ctl_wdata[CTL_UIE];
      ctl_d.oie = ctl_wdata[CTL_OIE];
    end
  end
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  // write arbitration and holding register
  logic [LVL_W-1:0]  lvl;
  logic              full, empty, rd_ok, room;
  logic              unf_q, ovf_q;
  logic              new_acc, stall_blk, pend_try;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              ovf_set, unf_set, ovf_autoclr;
  logic              pend_v_q, pend_v_d;
  logic [DATA_W-1:0] pend_dat_q, pend_dat_d;
  logic              pend_ld;

  always_comb begin
    full      = (lvl == LVL_W'(DEPTH));
    empty     = (lvl == '0);
    rd_ok     = rd_en && !empty;
    room      = !full || rd_ok;
    new_acc   = res_valid && !pend_v_q;
    stall_blk = ovf_q && ctl_q.oie;
    pend_try  = pend_v_q && !stall_blk;
    wr_en     = (pend_try || new_acc) && room;
    wr_data   = pend_v_q ? pend_dat_q : res_data;
    ovf_set   = (pend_try || new_acc) && !room;
    unf_set   = rd_en && empty;
    ovf_autoclr = !ctl_q.oie && room;

    pend_v_d   = pend_v_q;
    pend_dat_d = pend_dat_q;
    pend_ld    = 1'b0;
    if (new_acc && !room) begin
      pend_v_d   = 1'b1;
      pend_dat_d = res_data;
      pend_ld    = 1'b1;
    end else if (pend_try && room) begin
      pend_v_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pend_v_q <= 1'b0;
    else         pend_v_q <= pend_v_d;
  end

  always_ff @(posedge clk) begin
    if (pend_ld) pend_dat_q <= pend_dat_d;
  end

  cvt_ofifo_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_ok),
    .rd_data (rd_data),
    .level   (lvl)
  );

  cvt_ofifo_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_sn),
    .unf_set (unf_set),
    .unf_clr (sts_we && sts_wdata[STS_UNF]),
    .ovf_set (ovf_set),
    .ovf_clr ((sts_we && sts_wdata[STS_OVF]) || ovf_autoclr),
    .unf_q   (unf_q),
    .ovf_q   (ovf_q)
  );

  cvt_ofifo_flush #(
    .CNT_W  (CNT_W),
    .MIN_IN (MIN_IN)
  ) u_flush (
    .clk      (clk),
    .rst_n    (rst_sn),
    .fl_req   (ctl_we && ctl_wdata[CTL_FL]),
    .conv_en  (ctl_q.en),
    .in_count (in_count),
    .go       (flush_go),
    .clr      (work_clr)
  );

  always_comb begin
    ctl_rdata          = '0;
    ctl_rdata[CTL_EN]  = ctl_q.en;
    ctl_rdata[CTL_UIE] = ctl_q.uie;
    ctl_rdata[CTL_OIE] = ctl_q.oie;
    sts_rdata          = '0;
    sts_rdata[STS_UNF] = unf_q;
    sts_rdata[STS_OVF] = ovf_q;
  end

  assign fifo_level = lvl;
  assign conv_hold  = pend_v_q;
  assign irq        = (unf_q && ctl_q.uie) || (ovf_q && ctl_q.oie);
endmodule

// File: rtl/cvt_ofifo_ctrl_chk.sv
module cvt_ofifo_ctrl_chk #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             conv_hold,
  input logic [LVL_W-1:0] fifo_level,
  input logic [3:0]       ctl_rdata,
  input logic [1:0]       sts_rdata,
  input logic             flush_go,
  input logic             work_clr,
  input logic             irq
);
  // R2
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  // R3
  a_r3_empty_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_level == '0) |=> sts_rdata[0]);

  // R4
  a_r4_hold_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_hold) |-> sts_rdata[1]);

  // R5
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_rdata != 2'b00));

  // R6
  a_r6_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rdata[1] && ctl_rdata[2] && !rd_en) |=> fifo_level <= $past(fifo_level));

  // R9
  a_r9_flush_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[3]);

  // R10
  a_r10_flush_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_go && work_clr));
endmodule

bind cvt_ofifo_ctrl cvt_ofifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .conv_hold  (conv_hold),
  .fifo_level (fifo_level),
  .ctl_rdata  (ctl_rdata),
  .sts_rdata  (sts_rdata),
  .flush_go   (flush_go),
  .work_clr   (work_clr),
  .irq        (irq)
);

// File: tb/cvt_ofifo_ctrl_test.sv
module cvt_ofifo_ctrl_test;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int CW = 6;
  localparam int MIN_IN = 4;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk, rst_n;
  logic res_valid;
  logic [DW-1:0] res_data;
  logic conv_hold, rd_en;
  logic [DW-1:0] rd_data;
  logic [LW-1:0] fifo_level;
  logic ctl_we;
  logic [3:0] ctl_wdata, ctl_rdata;
  logic sts_we;
  logic [1:0] sts_wdata, sts_rdata;
  logic [CW-1:0] in_count;
  logic flush_go, work_clr, irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];

  cvt_ofifo_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW), .MIN_IN(MIN_IN)) uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .conv_hold(conv_hold), .rd_en(rd_en), .rd_data(rd_data), .fifo_level(fifo_level),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .in_count(in_count), .flush_go(flush_go), .work_clr(work_clr), .irq(irq));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // driver: one result, expected value queued for the scoreboard
  task automatic push(input logic [DW-1:0] d);
    res_valid = 1'b1;
    res_data  = d;
    exp_q.push_back(d);
    step();
    res_valid = 1'b0;
  endtask

  // monitor: pop the oldest expected item and compare with the read port
  task automatic pop_chk(input string req);
    logic [DW-1:0] e;
    e = exp_q.pop_front();
    chk(req, rd_data, e);
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  task automatic ctl_wr(input logic [3:0] v);
    ctl_we = 1'b1;
    ctl_wdata = v;
    step();
    ctl_we = 1'b0;
  endtask

  task automatic sts_clr(input logic [1:0] v);
    sts_we = 1'b1;
    sts_wdata = v;
    step();
    sts_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; res_valid = 0; res_data = '0; rd_en = 0;
    ctl_we = 0; ctl_wdata = '0; sts_we = 0; sts_wdata = '0; in_count = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 level", fifo_level, 0);
    chk("R1 status", sts_rdata, 0);
    chk("R1 ctl", ctl_rdata, 0);
    chk("R1 outs", {irq, conv_hold, flush_go, work_clr}, 0);

    // R2 ordering
    ctl_wr(4'b0011);
    chk("R9 readback", ctl_rdata, 4'b0011);
    push(16'h1111); push(16'h2222); push(16'h3333);
    chk("R2 level", fifo_level, 3);
    for (int i = 0; i < 3; i++) pop_chk("R2 order");
    chk("R2 drained", fifo_level, 0);

    // R3 underflow, R5 irq
    rd_en = 1'b1; step(); rd_en = 1'b0;
    chk("R3 flag", sts_rdata[0], 1);
    chk("R3 level", fifo_level, 0);
    chk("R5 irq unf", irq, 1);

    // R8 set beats clear
    rd_en = 1'b1; sts_we = 1'b1; sts_wdata = 2'b01; step();
    rd_en = 1'b0; sts_we = 1'b0;
    chk("R8 set wins", sts_rdata[0], 1);
    sts_clr(2'b01);
    chk("R8 cleared", sts_rdata[0], 0);
    chk("R5 irq drop", irq, 0);

    // R5 gated by enable
    ctl_wr(4'b0001);
    rd_en = 1'b1; step(); rd_en = 1'b0;
    chk("R5 flag no irq", {sts_rdata[0], irq}, 2'b10);
    sts_clr(2'b01);

    // R4 / R6 stall policy
    ctl_wr(4'b0101);
    for (int i = 0; i < 8; i++) push(DW'(16'hA000 + i));
    chk("R2 full", fifo_level, 8);
    push(16'hA0FF);
    chk("R4 flag", sts_rdata[1], 1);
    chk("R4 hold", conv_hold, 1);
    chk("R4 level", fifo_level, 8);
    chk("R5 irq ovf", irq, 1);
    pop_chk("R6 order"); pop_chk("R6 order");
    step(); step();
    chk("R6 still held", {conv_hold, fifo_level}, {1'b1, 4'd6});
    sts_clr(2'b10);
    chk("R6 flag cleared", {sts_rdata[1], fifo_level}, {1'b0, 4'd6});
    step();
    chk("R6 released", {conv_hold, fifo_level}, {1'b0, 4'd7});
    for (int i = 0; i < 7; i++) pop_chk("R11 stall order");
    chk("R11 stall empty", fifo_level, 0);

    // R7 auto policy
    ctl_wr(4'b0001);
    for (int i = 0; i < 8; i++) push(DW'(16'hB000 + i));
    push(16'hB0FF);
    chk("R7 flag no irq", {sts_rdata[1], conv_hold, irq}, 3'b110);
    step();
    chk("R7 still set", sts_rdata[1], 1);
    pop_chk("R7 order");
    chk("R7 autoclear", {sts_rdata[1], conv_hold, fifo_level}, {2'b00, 4'd8});
    for (int i = 0; i < 8; i++) pop_chk("R11 auto order");
    chk("R11 auto empty", fifo_level, 0);

    // R9 flush ignored when disabled
    ctl_wr(4'b0000);
    in_count = CW'(MIN_IN + 2);
    ctl_wr(4'b1000);
    chk("R9 disabled", {flush_go, work_clr}, 2'b00);
    chk("R9 reads zero", ctl_rdata[3], 0);

    // R10 flush threshold
    ctl_wr(4'b0001);
    in_count = CW'(MIN_IN);
    ctl_wr(4'b1001);
    chk("R10 go", {flush_go, work_clr}, 2'b10);
    step();
    chk("R10 go pulse", flush_go, 0);
    in_count = CW'(MIN_IN - 1);
    ctl_wr(4'b1001);
    chk("R10 clear", {flush_go, work_clr}, 2'b01);
    chk("R9 readback en", ctl_rdata, 4'b0001);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule